// File: doc/BRIEF.md
# Pulse-Width Coded Serial Word Transmitter

This block sends a control word to a remote, galvanically isolated converter or DAC over a single line. Each bit is sent as one high pulse, and the length of that pulse tells the receiver whether the bit is a zero or a one. After the last data bit, a pulse of a third length tells the receiver to latch the accumulated bits into its parallel register. No separate clock or latch wire is needed, which suits a single opto-coupled channel.

The host places a word and its bit count on the inputs and raises `start_i` for one cycle. The block captures both, raises `busy_o`, and plays out the frame. The default timing assumes a 655.36 kHz system clock. The pulse lengths are rounded to whole system-clock cycles: a zero bit lasts about 18 µs (12 cycles), a one bit about 50 µs (33 cycles), and the strobe about 20 µs (13 cycles). The low gaps between pulses are measured in ticks of a divide-by-8 clock, which runs at 81.92 kHz. When the final gap ends, `busy_o` falls and `done_o` pulses for one cycle.

Top module: `pwm_word_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `line_o` is low and `done_o` is low.
- R2: A data bit of value 0 is sent as a high pulse of exactly ZERO_CYC cycles (default 12).
- R3: A data bit of value 1 is sent as a high pulse of exactly ONE_CYC cycles (default 33).
- R4: The frame carries bits `len-1` down to 0 of the captured word, most significant first. Data bits at positions `len` and above have no effect on the line.
- R5: After the data bits, one strobe pulse of exactly STROBE_CYC cycles (default 13) is sent.
- R6: Every pulse, including the strobe, is followed by a low gap of exactly GAP_TICKS × CLK_DIV cycles (default 1 × 8).
- R7: `busy_o` rises in the cycle after an accepted start. The line stays low for that one cycle, and the first pulse starts in the next cycle. `busy_o` falls in the cycle after the strobe's gap ends, and `done_o` is high for exactly that one cycle.
- R8: A start request while `busy_o` is high is ignored. The word and length are captured at the accepted start, so later changes on `data_i` and `len_i` do not alter the frame in progress.
- R9: A length of 0 sends only the strobe. A length above DATA_W is treated as DATA_W.
- R10: Reset during a frame returns the block to idle, with `line_o`, `busy_o` and `done_o` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send a frame; ignored while busy |
| data_i | input | DATA_W | Word to send; its low `len_i` bits are used |
| len_i | input | LEN_W | Number of data bits in the frame |
| line_o | output | 1 | Pulse-width coded serial output |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when the frame ends |

## Verification
Random words are sent with random lengths, and garbage is placed above each length. A wrong bit order or a failure to ignore the upper bits then shows up as pulses of the wrong width in specific slots. Directed frames cover specific cases:
- All-zero and all-one words, which separate the zero width from the one width.
- Lengths of 0 and 12, and an over-long length of 15, which test the strobe-only frame and the clamp.
- A start request raised during the first pulse, while `data_i` and `len_i` are also changed, which shows that both the request and the new inputs are ignored.

The line is compared cycle by cycle against a waveform the bench builds on its own. A reset in the middle of a frame must return the block to idle.

// File: rtl/pwtx_pkg.sv
// Shared types and helpers for the pulse-width coded transmitter.
package pwtx_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } pwtx_state_t;

    // Largest of three integers, used to size the width counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwtx_tick_div.sv
// Tick generator: divides the system clock by DIV while enabled.
// Assumes DIV >= 2. Clearing restarts the phase, so the first tick
// comes exactly DIV enabled cycles after the clear.
module pwtx_tick_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Phase counter: wraps after DIV cycles, restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwtx_bit_queue.sv
// Bit queue: captures a word and a length, then hands out the bits
// most significant first. The word is stored left-aligned so that the
// current bit is always the top bit. Lengths above DATA_W are clamped.
module pwtx_bit_queue #(
    parameter int DATA_W = 12,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  logic              advance,
    output logic              cur_bit,
    output logic              empty
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_eff;

    // Clamp the requested length to the word width.
    always_comb begin
        len_eff = (len > LEN_MAX) ? LEN_MAX : len;
    end

    assign cur_bit = sh_q[DATA_W-1];
    assign empty   = (rem_q == '0);

    // Capture the word left-aligned, or shift one bit out per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rem_q <= '0;
        end else if (load) begin
            sh_q  <= data << (DATA_W - int'(len_eff));
            rem_q <= len_eff;
        end else if (advance && !empty) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            rem_q <= rem_q - 1'b1;
        end
    end
endmodule

// File: rtl/pwtx_width_timer.sv
// Down-counter for pulse widths. Loading sets the count to width-1.
// While running it counts down to zero, and it reports expiry at zero.
module pwtx_width_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    // Load a new width or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pwm_word_tx.sv
// Pulse-width coded word transmitter, top level.
// On an accepted start it captures the word and waits one setup cycle.
// It then sends one high pulse per bit (zero or one width), a strobe
// pulse, and a low gap of GAP_TICKS divided-clock periods after each
// pulse. Assumes all widths are >= 1, GAP_TICKS >= 1 and CLK_DIV >= 2.
module pwm_word_tx
    import pwtx_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEN_W      = $clog2(DATA_W + 1),
    parameter int CLK_DIV    = 8,
    parameter int ZERO_CYC   = 12,
    parameter int ONE_CYC    = 33,
    parameter int STROBE_CYC = 13,
    parameter int GAP_TICKS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int W_MAX = max3(ZERO_CYC, ONE_CYC, STROBE_CYC);
    localparam int CW    = $clog2(W_MAX + 1);
    localparam int GW    = $clog2(GAP_TICKS + 1);
    localparam logic [CW-1:0] W0_LD = CW'(ZERO_CYC - 1);
    localparam logic [CW-1:0] W1_LD = CW'(ONE_CYC - 1);
    localparam logic [CW-1:0] WS_LD = CW'(STROBE_CYC - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

    pwtx_state_t   st_q;
    logic          line_q, busy_q, done_q, strobe_q;
    logic [GW-1:0] gap_cnt_q;

    logic          q_bit, q_empty, tmr_exp, tick;
    logic          accept, launch, pulse_end, gap_end;
    logic [CW-1:0] launch_w;

    assign accept    = (st_q == ST_IDLE) && start_i;
    assign pulse_end = (st_q == ST_PULSE) && tmr_exp;
    assign gap_end   = (st_q == ST_GAP) && tick && (gap_cnt_q == GAP_LAST);
    assign launch    = (st_q == ST_LOAD) || (gap_end && !strobe_q);

    // Pick the width of the next pulse from the head of the queue.
    always_comb begin
        if (q_empty)    launch_w = WS_LD;
        else if (q_bit) launch_w = W1_LD;
        else            launch_w = W0_LD;
    end

    pwtx_bit_queue #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .data    (data_i),
        .len     (len_i),
        .advance (launch && !q_empty),
        .cur_bit (q_bit),
        .empty   (q_empty)
    );

    pwtx_width_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (launch_w),
        .run      (st_q == ST_PULSE),
        .expired  (tmr_exp)
    );

    pwtx_tick_div #(
        .DIV (CLK_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pulse_end),
        .en    (st_q == ST_GAP),
        .tick  (tick)
    );

    // Count divided-clock ticks within a gap.
    always_ff @(posedge clk) begin
        if (!rst_n || pulse_end) begin
            gap_cnt_q <= '0;
        end else if ((st_q == ST_GAP) && tick && !gap_end) begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    // Frame sequencer: idle, setup, pulse and gap phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            line_q   <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q   <= ST_LOAD;
                        busy_q <= 1'b1;
                    end
                end
                ST_LOAD: begin
                    st_q     <= ST_PULSE;
                    line_q   <= 1'b1;
                    strobe_q <= q_empty;
                end
                ST_PULSE: begin
                    if (tmr_exp) begin
                        st_q   <= ST_GAP;
                        line_q <= 1'b0;
                    end
                end
                ST_GAP: begin
                    if (gap_end && strobe_q) begin
                        st_q   <= ST_IDLE;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else if (gap_end) begin
                        st_q     <= ST_PULSE;
                        line_q   <= 1'b1;
                        strobe_q <= q_empty;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign line_o = line_q;
    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/pwtx_checker.sv
// Protocol checker for pwm_word_tx. It measures high and low run
// lengths on the line and relates them to busy and done.
module pwtx_checker #(
    parameter int CLK_DIV    = 8,
    parameter int ZERO_CYC   = 12,
    parameter int ONE_CYC    = 33,
    parameter int STROBE_CYC = 13,
    parameter int GAP_TICKS  = 1
) (
    input logic clk,
    input logic rst_n,
    input logic line_o,
    input logic busy_o,
    input logic done_o
);
    localparam int GAP_CYC = GAP_TICKS * CLK_DIV;

    int   hi_cnt, lo_cnt;
    logic prev_line, seen_fall;

    // Track run lengths and whether a gap has started in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= 0;
            lo_cnt    <= 0;
            prev_line <= 1'b0;
            seen_fall <= 1'b0;
        end else begin
            hi_cnt    <= line_o ? hi_cnt + 1 : 0;
            lo_cnt    <= line_o ? 0 : lo_cnt + 1;
            prev_line <= line_o;
            if (done_o)                    seen_fall <= 1'b0;
            else if (prev_line && !line_o) seen_fall <= 1'b1;
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_o);

    // Pulse widths must be one of the zero (R2), one (R3) or strobe (R5) lengths.
    p_width_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_o) |-> (hi_cnt == ZERO_CYC || hi_cnt == ONE_CYC || hi_cnt == STROBE_CYC));

    p_gap_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_o) && seen_fall) |-> (lo_cnt == GAP_CYC));

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($fell(busy_o) && lo_cnt == GAP_CYC));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind pwm_word_tx pwtx_checker #(
    .CLK_DIV    (CLK_DIV),
    .ZERO_CYC   (ZERO_CYC),
    .ONE_CYC    (ONE_CYC),
    .STROBE_CYC (STROBE_CYC),
    .GAP_TICKS  (GAP_TICKS)
) u_pwtx_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_o (line_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/pwm_word_tx_test.sv
// Bench for pwm_word_tx: builds each frame's expected waveform and
// compares the line, busy and done cycle by cycle.
module pwm_word_tx_test;
    localparam int DATA_W = 12;
    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int T0 = 12, T1 = 33, TS = 13, GAP = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DATA_W-1:0] data_i = '0;
    logic [LEN_W-1:0]  len_i = '0;
    logic              line_o, busy_o, done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    pwm_word_tx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .data_i  (data_i),
        .len_i   (len_i),
        .line_o  (line_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int eff_len(input int len);
        return (len > DATA_W) ? DATA_W : len;
    endfunction

    function automatic int bit_width(input logic b);
        return b ? T1 : T0;
    endfunction

    // Check n cycles of fixed line/busy/done levels, sampled at negedge.
    task automatic expect_run(input int n, input logic ln, input logic bz,
                              input logic dn, input string tag);
        logic bad = 1'b0;
        logic [2:0] got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!bad && {line_o, busy_o, done_o} != {ln, bz, dn}) begin
                bad = 1'b1;
                got = {line_o, busy_o, done_o};
            end
        end
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual line/busy/done=%b expected=%b", tag, got, {ln, bz, dn});
        end
    endtask

    // Send one frame and compare the whole waveform; optionally poke
    // start and change the inputs during the first pulse (R8).
    task automatic run_frame(input logic [DATA_W-1:0] d, input int len, input logic poke);
        int n = eff_len(len);
        @(negedge clk);
        data_i  = d;
        len_i   = LEN_W'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = poke;
        if (poke) begin
            data_i = ~d;
            len_i  = LEN_W'(1);
        end
        // Setup cycle: busy, line still low (R7).
        if ({line_o, busy_o, done_o} != 3'b010) begin
            n_fail++;
            $display("FAIL R7 setup: actual=%b expected=010", {line_o, busy_o, done_o});
        end
        n_tests++;
        for (int i = n - 1; i >= 0; i--) begin
            expect_run(bit_width(d[i]), 1'b1, 1'b1, 1'b0, d[i] ? "R3/R4 one pulse" : "R2/R4 zero pulse");
            start_i = 1'b0;
            expect_run(GAP, 1'b0, 1'b1, 1'b0, "R6 gap");
        end
        expect_run(TS, 1'b1, 1'b1, 1'b0, "R5 strobe");
        start_i = 1'b0;
        expect_run(GAP, 1'b0, 1'b1, 1'b0, "R6 strobe gap");
        expect_run(1, 1'b0, 1'b0, 1'b1, "R7 done pulse");
        expect_run(3, 1'b0, 1'b0, 1'b0, "R8 no restart after ignored start");
    endtask

    initial begin
        void'($urandom(32'd617));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_run(2, 1'b0, 1'b0, 1'b0, "R1 reset idle");

        run_frame(12'h000, 12, 1'b0);            // R2 all zeros
        run_frame(12'hFFF, 12, 1'b0);            // R3 all ones
        run_frame(12'h801, 12, 1'b0);            // R4 MSB first
        run_frame(12'hFA5, 0, 1'b0);             // R9 strobe only
        run_frame(12'h5A3, 15, 1'b0);            // R9 clamp to DATA_W
        run_frame(12'hF02, 3, 1'b0);             // R4 upper bits ignored
        run_frame(12'h6C9, 8, 1'b1);             // R8 start and inputs ignored
        run_frame(12'h001, 1, 1'b0);             // R4 single bit

        for (int k = 0; k < 25; k++) begin
            run_frame(DATA_W'($urandom), int'($urandom_range(0, 13)), 1'($urandom_range(0, 1)));
        end

        // R10: reset in the middle of a frame.
        @(negedge clk);
        data_i  = 12'hABC;
        len_i   = LEN_W'(12);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_run(3, 1'b0, 1'b0, 1'b0, "R10 reset mid-frame");
        run_frame(12'h3C5, 12, 1'b0);            // R10 normal frame after reset

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule